// File: doc/BRIEF.md
# Share-Weighted Fairness Bus Arbiter

This block decides which of N masters may drive a single shared slave port. Every master has a request line of its own and receives a grant line of its own. Each master also has an integer share count that sets how many transfers it may make in one arbitration round. The holder of the grant pulses a done strobe at the end of each transfer, and each strobe uses up one of its shares. The grant passes on when the holder's budget runs out or when the holder withdraws its request.

When the grant becomes free, the arbiter looks at the requesters that still have budget and picks the one with the largest configured share count. A tie goes to the lower index. When no requester has budget left, every budget is refilled from its share count and a new round begins. If all masters keep requesting, each one holds the bus for its share count of transfers in every round. Its long-run fraction of bus time is therefore its shares divided by the sum of all shares.

A share count of zero counts as one, so that master is still served. A master that is the only requester keeps the grant for as long as it likes. Address decoding, data steering and the transfer protocol are left to the surrounding fabric.

Top module: `share_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle. Bit i set means master i holds the bus.
- R2: The grant is registered. A master can be granted only if its `req` bit was high at the previous clock edge. When no master requests, `gnt` is all zero one cycle later.
- R3: `gnt` changes only in the cycle after one of these three events: no grant was held, the holder pulsed `xfer_done`, or the holder's `req` bit was low.
- R4: Each `xfer_done` pulse while a grant is held uses up one share of the holder's budget. The holder keeps the grant while it still requests and still has budget left, and no budget ever exceeds its effective share count.
- R5: When a new holder is chosen, the winner is the requester with remaining budget that has the largest effective share count. On a tie, the lowest index wins.
- R6: When no requester has budget left, all budgets are refilled from the share inputs and a new round starts, ordered as in R5. With all masters requesting, master i makes exactly its effective share count of transfers per round.
- R7: A share value of 0 behaves exactly like a share value of 1.
- R8: A master that is the only requester keeps its grant across any number of `xfer_done` pulses.
- R9: When the holder lowers its request, the grant leaves it at the next clock edge. The shares it has not used stay available to it for the rest of the round.
- R10: While `rst_n` is low, `gnt` is all zero and every budget is emptied, so the first arbitration after reset starts a fresh round.
- R11: An `xfer_done` pulse while no grant is held changes no budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Bus request, one bit per master |
| share_cfg | input | N*W | Share count of each master; master i uses bits [i*W +: W] |
| xfer_done | input | 1 | One-cycle strobe from the holder marking the end of one transfer |
| gnt | output | N | Bus grant, one bit per master, at most one set |

## Verification
Two functions can fall in the same clock edge. In one, the holder spends its last share and a new holder must be picked while all budgets are refilled. In the other, the holder withdraws its request while its done pulse is still being counted. The vector table drives every master continuously through a full round with mixed share counts and a tie, so the edge that spends the last share is also the reload edge. It is judged by which master holds the grant on the next cycle. Directed sequences withdraw a request part-way through a budget and then count the transfers the master makes when it returns. The count shows whether the remaining shares survived and whether the master lost them.

// File: rtl/share_arbiter_pkg.sv
package share_arbiter_pkg;

  // Effective share count: a zero setting is served as one share.
  function automatic logic [31:0] at_least_one(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

  // Budget after one transfer, never wrapping below zero.
  function automatic logic [31:0] spend_one(input logic [31:0] left, input logic take);
    return (take && left != 32'd0) ? left - 32'd1 : left;
  endfunction

endpackage

// File: rtl/share_arbiter_budget.sv
module share_arbiter_budget #(
  parameter int N = 4,
  parameter int W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*W-1:0]   share_cfg,
  input  logic             take_en,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             refill,
  output logic [N*W-1:0]   eff_flat,
  output logic [N*W-1:0]   rem_flat,
  output logic [N*W-1:0]   rem_next_flat
);
  import share_arbiter_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [W-1:0] eff_g;
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_d;
    logic         hit_g;

    assign hit_g = take_en && (take_idx == IDX_W'(g));
    assign eff_g = W'(at_least_one(32'(share_cfg[g*W +: W])));
    assign rem_d = W'(spend_one(32'(rem_q), hit_g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rem_q <= '0;
      else if (refill) rem_q <= eff_g;
      else             rem_q <= rem_d;
    end

    assign eff_flat[g*W +: W]      = eff_g;
    assign rem_flat[g*W +: W]      = rem_q;
    assign rem_next_flat[g*W +: W] = rem_d;
  end

endmodule

// File: rtl/share_arbiter_pick.sv
module share_arbiter_pick #(
  parameter int N = 4,
  parameter int W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [N*W-1:0]   weight,
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);
  logic [W-1:0] best_w;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best_w  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || weight[i*W +: W] > best_w)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best_w  = weight[i*W +: W];
      end
    end
  end

endmodule

// File: rtl/share_arbiter.sv
module share_arbiter #(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] share_cfg,
  input  logic           xfer_done,
  output logic [N-1:0]   gnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             own_vld;
  logic [IDX_W-1:0] own_idx;
  logic [N*W-1:0]   eff_flat;
  logic [N*W-1:0]   rem_flat;
  logic [N*W-1:0]   rem_next_flat;
  logic [N-1:0]     rem_left;
  logic [N-1:0]     elig;
  logic [N-1:0]     cand;
  logic             found;
  logic [IDX_W-1:0] win_idx;

  // Named events, also watched by the checker.
  logic hold_done;
  logic own_req;
  logic spent_ev;
  logic release_ev;
  logic refill_ev;

  always_comb begin
    for (int i = 0; i < N; i++) rem_left[i] = (rem_next_flat[i*W +: W] != '0);
  end

  assign hold_done  = own_vld && xfer_done;
  assign own_req    = own_vld && req[own_idx];
  assign spent_ev   = hold_done && !rem_left[own_idx];
  assign release_ev = !own_vld || !own_req || spent_ev;
  assign elig       = req & rem_left;
  assign refill_ev  = release_ev && (elig == '0) && (req != '0);
  assign cand       = refill_ev ? req : elig;

  share_arbiter_budget #(.N(N), .W(W)) u_budget (
    .clk          (clk),
    .rst_n        (rst_n),
    .share_cfg    (share_cfg),
    .take_en      (hold_done),
    .take_idx     (own_idx),
    .refill       (refill_ev),
    .eff_flat     (eff_flat),
    .rem_flat     (rem_flat),
    .rem_next_flat(rem_next_flat)
  );

  share_arbiter_pick #(.N(N), .W(W)) u_pick (
    .cand   (cand),
    .weight (eff_flat),
    .found  (found),
    .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (release_ev) begin
      own_vld <= found;
      own_idx <= win_idx;
    end
  end

  always_comb begin
    gnt = '0;
    if (own_vld) gnt[own_idx] = 1'b1;
  end

endmodule

// File: rtl/share_arbiter_chk.sv
module share_arbiter_chk #(
  parameter int N = 4,
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic           xfer_done,
  input logic [N-1:0]   gnt,
  input logic [N*W-1:0] rem_flat,
  input logic [N*W-1:0] eff_flat
);

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  gnt_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> (($past(req) & gnt) != '0));

  // R3
  gnt_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gnt) |-> ($past(gnt) == '0 || $past(xfer_done) || ($past(gnt) & $past(req)) == '0));

  // R8
  sole_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && req == gnt) |=> (gnt == $past(gnt)));

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0 && xfer_done) |=> $stable(rem_flat));

  for (genvar g = 0; g < N; g++) begin : g_bound
    // R4
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_flat[g*W +: W] <= eff_flat[g*W +: W]);
  end

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_gnt_chk: assert (gnt == '0);
    end
  end

endmodule

bind share_arbiter share_arbiter_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .xfer_done(xfer_done),
  .gnt      (gnt),
  .rem_flat (rem_flat),
  .eff_flat (eff_flat)
);

// File: tb/share_arbiter_bench.sv
module share_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 4;

  // Vector layout: [8:5] req, [4] xfer_done, [3:0] expected gnt after the edge.
  // Shares: m0=3, m1=1, m2=2, m3=0 (served as 1).
  localparam logic [8:0] TBL [0:9] = '{
    {4'b1111, 1'b0, 4'b0001},
    {4'b1111, 1'b1, 4'b0001},
    {4'b1111, 1'b1, 4'b0001},
    {4'b1111, 1'b1, 4'b0100},
    {4'b1111, 1'b0, 4'b0100},
    {4'b1111, 1'b1, 4'b0100},
    {4'b1111, 1'b1, 4'b0010},
    {4'b1111, 1'b1, 4'b1000},
    {4'b1111, 1'b1, 4'b0001},
    {4'b1111, 1'b1, 4'b0001}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic [N*W-1:0] share_cfg = '0;
  logic           xfer_done = 1'b0;
  logic [N-1:0]   gnt;

  int n_checks = 0;
  int n_errors = 0;

  share_arbiter #(.N(N), .W(W)) u_share_arbiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .share_cfg(share_cfg),
    .xfer_done(xfer_done),
    .gnt      (gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [N-1:0] exp, input string tag);
    n_checks++;
    if (gnt !== exp) begin
      n_errors++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks after the next rising edge.
  task automatic cyc(input logic [N-1:0] r, input logic d, input logic [N-1:0] exp,
                     input string tag);
    req = r;
    xfer_done = d;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    check('0, "R10 gnt low in reset");
    rst_n = 1'b1;
  endtask

  function automatic logic [N*W-1:0] shares(input int s0, input int s1, input int s2, input int s3);
    return {W'(s3), W'(s2), W'(s1), W'(s0)};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Table walk: full round with mixed shares and a tie (R5, R6, R7, R4).
    share_cfg = shares(3, 1, 2, 0);
    do_reset();
    for (int i = 0; i < 10; i++) begin
      cyc(TBL[i][8:5], TBL[i][4], TBL[i][3:0], $sformatf("R6 round vector %0d", i));
    end

    // R10 / R2: after reset with no requests nothing is granted.
    do_reset();
    cyc(4'b0000, 1'b0, 4'b0000, "R2 no request no grant");

    // R8: sole requester keeps the grant past its budget.
    share_cfg = shares(1, 4, 4, 4);
    do_reset();
    cyc(4'b0001, 1'b0, 4'b0001, "R8 sole grant");
    cyc(4'b0001, 1'b1, 4'b0001, "R8 sole after done 1");
    cyc(4'b0001, 1'b1, 4'b0001, "R8 sole after done 2");
    cyc(4'b0001, 1'b1, 4'b0001, "R8 sole after done 3");

    // R7: zero shares act as one share each.
    share_cfg = shares(0, 0, 5, 5);
    do_reset();
    cyc(4'b0011, 1'b0, 4'b0001, "R7 zero-share first");
    cyc(4'b0011, 1'b1, 4'b0010, "R7 zero-share one transfer");
    cyc(4'b0011, 1'b1, 4'b0001, "R7 zero-share reload");

    // R3 / R5: holder keeps the bus without done even with a heavier contender.
    share_cfg = shares(1, 5, 1, 1);
    do_reset();
    cyc(4'b0001, 1'b0, 4'b0001, "R3 lone grant");
    cyc(4'b0011, 1'b0, 4'b0001, "R3 hold no done 1");
    cyc(4'b0011, 1'b0, 4'b0001, "R3 hold no done 2");
    cyc(4'b0011, 1'b1, 4'b0010, "R5 pass to next after spent");

    // R9: withdrawn request releases, unused shares survive.
    share_cfg = shares(3, 2, 1, 1);
    do_reset();
    cyc(4'b0111, 1'b0, 4'b0001, "R9 largest first");
    cyc(4'b0111, 1'b1, 4'b0001, "R9 one share used");
    cyc(4'b0110, 1'b0, 4'b0010, "R9 release on drop");
    cyc(4'b0111, 1'b1, 4'b0010, "R9 second holder");
    cyc(4'b0111, 1'b1, 4'b0001, "R9 return with remainder");
    cyc(4'b0111, 1'b1, 4'b0001, "R9 remainder 1 left");
    cyc(4'b0111, 1'b1, 4'b0100, "R9 remainder spent");

    // R11: done with no holder touches no budget.
    share_cfg = shares(2, 1, 1, 1);
    do_reset();
    cyc(4'b0011, 1'b0, 4'b0001, "R11 grant m0");
    cyc(4'b0011, 1'b1, 4'b0001, "R11 m0 one left");
    cyc(4'b0000, 1'b0, 4'b0000, "R2 all drop");
    cyc(4'b0000, 1'b1, 4'b0000, "R11 idle done 1");
    cyc(4'b0000, 1'b1, 4'b0000, "R11 idle done 2");
    cyc(4'b0011, 1'b0, 4'b0001, "R11 m0 regranted");
    cyc(4'b0011, 1'b1, 4'b0010, "R11 m0 had exactly one left");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule